// File: doc/BRIEF.md
# Vector Narrowing Pack Unit

This unit reduces two 128-bit source vectors to a single 128-bit result. Each element of both sources is narrowed to half its width. The narrowed elements of the first source fill the upper half of the result, and those of the second source fill the lower half. Two element sizes are supported: 16-bit to 8-bit and 32-bit to 16-bit. Each size can be narrowed in one of four ways:

- plain truncation;
- unsigned clamping;
- signed clamping;
- signed-in, unsigned-out clamping, where negative elements become zero.

A ninth operation compresses 32-bit 8:8:8:8 pixels into 16-bit 1:5:5:5 pixels.

The operation is chosen by a 6-bit major opcode and an 11-bit minor opcode, as an instruction decoder in a vector pipeline would present them. The result is registered, so it appears one clock after the operands. A sticky flag records whether any element was clamped since software last cleared it.

Top module: `lane_narrow_pack`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise, so each result appears exactly one clock after its operands.
- R2: Minor code 0x00E truncates each 16-bit element to its low 8 bits. Minor code 0x04E truncates each 32-bit element to its low 16 bits. Neither code ever sets the sticky flag.
- R3: Minor codes 0x08E (16→8) and 0x0CE (32→16) read elements as unsigned. Values above the narrow maximum become 0xFF or 0xFFFF respectively.
- R4: Minor codes 0x18E (16→8) and 0x1CE (32→16) read elements as signed and clamp them to the signed narrow range. The 16→8 range is 0x80 to 0x7F; the 32→16 range is 0x8000 to 0x7FFF.
- R5: Minor codes 0x10E (16→8) and 0x14E (32→16) read elements as signed. A negative element gives zero. A positive element above the unsigned narrow maximum gives all ones.
- R6: Minor code 0x30E maps each 32-bit word w to a 16-bit value made of w[24], w[23:19], w[15:11] and w[7:3], from the most significant field to the least.
- R7: The narrowed elements of `src_a` occupy result[127:64] and those of `src_b` occupy result[63:0]. Each element keeps its lane order, so source lane j (counting from bit 0) goes to narrow lane j.
- R8: A minor code outside the nine listed, or a major opcode other than 4, gives a zero result with `illegal` high. Such an operation never sets the sticky flag.
- R9: The sticky flag is set after any valid saturating operation in which at least one element's result differs numerically from its source. A negative input under R5 counts as such a difference. Once set, the flag stays set until it is cleared.
- R10: `sat_clear` clears the flag at the next edge. If a clamping operation is accepted in the same cycle as `sat_clear`, the flag ends set.
- R11: While `in_valid` is low, `result` and `illegal` keep their previous values.
- R12: After reset, `result`, `illegal`, `out_valid` and `sat_sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | Operands and opcodes are valid this cycle |
| major_op | input | 6 | Major opcode; must be 4 |
| minor_op | input | 11 | Selects the narrowing operation |
| src_a | input | 128 | First source; its results go to the upper half |
| src_b | input | 128 | Second source; its results go to the lower half |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 128 | Narrowed vector |
| illegal | output | 1 | The last accepted opcode was not recognised |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
Setting and clearing the sticky flag can fall in the same cycle. The bench drives `sat_clear` together with a clamping operation, and separately together with a non-clamping one. It expects the flag to end set in the first case and clear in the second. It also drives `sat_clear` with no operation while the flag is already set. A behavioural reference model tracks the flag and all the other outputs on every clock.

// File: rtl/npk_pkg.sv
package npk_pkg;
  localparam int unsigned MAJOR_W   = 6;
  localparam int unsigned MINOR_W   = 11;
  localparam logic [MAJOR_W-1:0] MAJOR_VEC = 6'd4;

  typedef enum logic [1:0] {K_MOD, K_USAT, K_SSAT, K_S2U} clamp_kind_e;
  typedef enum logic [1:0] {G_HALF, G_WORD, G_PIX} group_e;

  typedef struct packed {
    logic        legal;
    group_e      grp;
    clamp_kind_e kind;
  } op_dec_t;
endpackage

// File: rtl/npk_decode.sv
module npk_decode
  import npk_pkg::*;
(
  input  logic [MAJOR_W-1:0] major_op,
  input  logic [MINOR_W-1:0] minor_op,
  output op_dec_t            dec
);
  always_comb begin
    dec = '{legal: 1'b1, grp: G_HALF, kind: K_MOD};
    case (minor_op)
      11'h00E: dec = '{legal: 1'b1, grp: G_HALF, kind: K_MOD};
      11'h04E: dec = '{legal: 1'b1, grp: G_WORD, kind: K_MOD};
      11'h08E: dec = '{legal: 1'b1, grp: G_HALF, kind: K_USAT};
      11'h0CE: dec = '{legal: 1'b1, grp: G_WORD, kind: K_USAT};
      11'h10E: dec = '{legal: 1'b1, grp: G_HALF, kind: K_S2U};
      11'h14E: dec = '{legal: 1'b1, grp: G_WORD, kind: K_S2U};
      11'h18E: dec = '{legal: 1'b1, grp: G_HALF, kind: K_SSAT};
      11'h1CE: dec = '{legal: 1'b1, grp: G_WORD, kind: K_SSAT};
      11'h30E: dec = '{legal: 1'b1, grp: G_PIX,  kind: K_MOD};
      default: dec.legal = 1'b0;
    endcase
    if (major_op != MAJOR_VEC) dec.legal = 1'b0;
  end
endmodule

// File: rtl/npk_elem.sv
module npk_elem
  import npk_pkg::*;
#(
  parameter int unsigned WIDE = 16
)(
  input  clamp_kind_e        kind,
  input  logic [WIDE-1:0]    x,
  output logic [WIDE/2-1:0]  y,
  output logic               clamped
);
  localparam int unsigned N = WIDE / 2;
  localparam logic [N-1:0] UMAX = '1;
  localparam logic [N-1:0] SMAX = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] SMIN = {1'b1, {(N-1){1'b0}}};

  logic            hi_zero;
  logic            fits_signed;
  logic [WIDE-1:0] xz;
  logic            xz_hi_zero;

  always_comb begin
    hi_zero     = ~|x[WIDE-1:N];
    fits_signed = (&x[WIDE-1:N-1]) | ~|x[WIDE-1:N-1];
    // negative values are forced to zero by masking with the inverted sign fill
    xz          = x & ~{WIDE{x[WIDE-1]}};
    xz_hi_zero  = ~|xz[WIDE-1:N];
    case (kind)
      K_USAT: begin
        clamped = ~hi_zero;
        y       = hi_zero ? x[N-1:0] : UMAX;
      end
      K_SSAT: begin
        clamped = ~fits_signed;
        y       = fits_signed ? x[N-1:0] : (x[WIDE-1] ? SMIN : SMAX);
      end
      K_S2U: begin
        clamped = x[WIDE-1] | ~xz_hi_zero;
        y       = xz_hi_zero ? xz[N-1:0] : UMAX;
      end
      default: begin
        clamped = 1'b0;
        y       = x[N-1:0];
      end
    endcase
  end
endmodule

// File: rtl/npk_pixel.sv
module npk_pixel #(
  parameter int unsigned LANES = 4
)(
  input  logic [32*LANES-1:0] words,
  output logic [16*LANES-1:0] pix
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [31:0] w;
    assign w = words[32*j +: 32];
    assign pix[16*j +: 16] = {w[24], w[23:19], w[15:11], w[7:3]};
  end
endmodule

// File: rtl/lane_narrow_pack.sv
module lane_narrow_pack
  import npk_pkg::*;
#(
  parameter int unsigned VEC_W = 128
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [5:0]         major_op,
  input  logic [10:0]        minor_op,
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  input  logic               sat_clear,
  output logic               out_valid,
  output logic [VEC_W-1:0]   result,
  output logic               illegal,
  output logic               sat_sticky
);
  localparam int unsigned HALF_LANES = VEC_W / 16;
  localparam int unsigned WORD_LANES = VEC_W / 32;
  localparam int unsigned OUT_HALF   = VEC_W / 2;

  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rsync;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_ok = rsync[1];

  op_dec_t dec;
  npk_decode u_dec (.major_op(major_op), .minor_op(minor_op), .dec(dec));

  logic [1:0][VEC_W-1:0] src;
  assign src = {src_a, src_b};

  for (genvar s = 0; s < 2; s++) begin : g_src
    logic [OUT_HALF-1:0]   nh, nw, np, pick;
    logic [HALF_LANES-1:0] ch;
    logic [WORD_LANES-1:0] cw;
    logic                  any_c;

    for (genvar j = 0; j < HALF_LANES; j++) begin : g_h
      npk_elem #(.WIDE(16)) u_h (
        .kind(dec.kind), .x(src[s][16*j +: 16]), .y(nh[8*j +: 8]), .clamped(ch[j]));
    end
    for (genvar j = 0; j < WORD_LANES; j++) begin : g_w
      npk_elem #(.WIDE(32)) u_w (
        .kind(dec.kind), .x(src[s][32*j +: 32]), .y(nw[16*j +: 16]), .clamped(cw[j]));
    end
    npk_pixel #(.LANES(WORD_LANES)) u_p (.words(src[s]), .pix(np));

    always_comb begin
      case (dec.grp)
        G_HALF:  begin pick = nh; any_c = |ch; end
        G_WORD:  begin pick = nw; any_c = |cw; end
        default: begin pick = np; any_c = 1'b0; end
      endcase
    end
  end

  // next-state
  logic [VEC_W-1:0] res_d;
  logic             ill_d, sat_d, clamp_hit;
  always_comb begin
    clamp_hit = in_valid & dec.legal & (g_src[1].any_c | g_src[0].any_c);
    res_d     = dec.legal ? {g_src[1].pick, g_src[0].pick} : '0;
    ill_d     = ~dec.legal;
    sat_d     = (sat_sticky & ~sat_clear) | clamp_hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      out_valid  <= 1'b0;
      result     <= '0;
      illegal    <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      sat_sticky <= sat_d;
      if (in_valid) begin
        result  <= res_d;
        illegal <= ill_d;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid);
  a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> ($stable(result) && $stable(illegal)));
  a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && illegal) |-> (result == '0));
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    (sat_sticky && !sat_clear) |=> sat_sticky);
  a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_ok)
    (sat_clear && !in_valid) |=> !sat_sticky);
  a_r2_modulo_no_sat: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && (minor_op == 11'h00E || minor_op == 11'h04E) && !sat_sticky && !sat_clear)
      |=> !sat_sticky);
endmodule

// File: tb/sim_lane_narrow_pack.sv
`timescale 1ns/1ps
module sim_lane_narrow_pack;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [5:0]   major_op = 6'd4;
  logic [10:0]  minor_op = 11'h00E;
  logic [127:0] src_a = '0, src_b = '0;
  logic         sat_clear = 1'b0;
  logic         out_valid, illegal, sat_sticky;
  logic [127:0] result;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [127:0] exp_res = '0;
  bit exp_ill = 0, exp_sat = 0, exp_vld = 0;

  always #2.5 clk = ~clk;

  lane_narrow_pack u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .major_op(major_op),
    .minor_op(minor_op), .src_a(src_a), .src_b(src_b), .sat_clear(sat_clear),
    .out_valid(out_valid), .result(result), .illegal(illegal), .sat_sticky(sat_sticky));

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference of one operation
  function automatic logic [127:0] ref_pack(input logic [5:0] mj, input logic [10:0] mn,
      input logic [127:0] a, input logic [127:0] b, output bit sat, output bit ill);
    logic [127:0] r = '0, t, srcv;
    int w, kind; // kind 0 mod 1 usat 2 ssat 3 s2u 4 pixel
    longint u, sv, y, umax, smax, smin;
    sat = 0; ill = 0;
    case (mn)
      11'h00E: begin w = 16; kind = 0; end
      11'h04E: begin w = 32; kind = 0; end
      11'h08E: begin w = 16; kind = 1; end
      11'h0CE: begin w = 32; kind = 1; end
      11'h18E: begin w = 16; kind = 2; end
      11'h1CE: begin w = 32; kind = 2; end
      11'h10E: begin w = 16; kind = 3; end
      11'h14E: begin w = 32; kind = 3; end
      11'h30E: begin w = 32; kind = 4; end
      default: begin w = 16; kind = 0; ill = 1; end
    endcase
    if (mj != 6'd4) ill = 1;
    if (ill) return '0;
    umax = (longint'(1) << (w/2)) - 1;
    smax = (longint'(1) << (w/2 - 1)) - 1;
    smin = -(longint'(1) << (w/2 - 1));
    for (int s = 0; s < 2; s++) begin
      srcv = (s == 0) ? a : b;
      for (int j = 0; j < 128 / w; j++) begin
        u  = longint'((srcv >> (j*w)) & ((128'd1 << w) - 1));
        sv = (u >= (longint'(1) << (w-1))) ? u - (longint'(1) << w) : u;
        case (kind)
          0: y = u & umax;
          1: begin y = (u > umax) ? umax : u; if (u > umax) sat = 1; end
          2: begin
            if (sv > smax) begin y = smax; sat = 1; end
            else if (sv < smin) begin y = smin & umax; sat = 1; end
            else y = sv & umax;
          end
          3: begin
            if (sv < 0) begin y = 0; sat = 1; end
            else if (sv > umax) begin y = umax; sat = 1; end
            else y = sv;
          end
          default: y = (((u >> 24) & 1) << 15) | (((u >> 19) & 31) << 10) |
                       (((u >> 11) & 31) << 5) | ((u >> 3) & 31);
        endcase
        t = 128'(y);
        r |= t << (j*(w/2) + ((s == 0) ? 64 : 0));
      end
    end
    return r;
  endfunction

  task automatic step(input bit v, input logic [10:0] mn, input logic [127:0] a,
      input logic [127:0] b, input bit clr, input string rtag, input string stag,
      input logic [5:0] mj = 6'd4);
    bit s, il;
    logic [127:0] r;
    @(negedge clk);
    in_valid = v; minor_op = mn; major_op = mj; src_a = a; src_b = b; sat_clear = clr;
    r = ref_pack(mj, mn, a, b, s, il);
    exp_vld = v;
    if (v) begin exp_res = r; exp_ill = il; end
    exp_sat = (exp_sat && !clr) || (v && !il && s);
    @(posedge clk); #1;
    chk("R1", "out_valid", 128'(out_valid), 128'(exp_vld));
    chk(rtag, "result", result, exp_res);
    chk("R8", "illegal", 128'(illegal), 128'(exp_ill));
    chk(stag, "sat_sticky", 128'(sat_sticky), 128'(exp_sat));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [127:0] HA = 128'h0000_007F_0080_00FF_0100_7FFF_8000_FFFF;
  localparam logic [127:0] HB = 128'hFF80_FF7F_1234_0001_FFFE_0042_7F00_8001;
  localparam logic [127:0] WA = 128'h0000_0000_0000_7FFF_0000_8000_0001_0000;
  localparam logic [127:0] WB = 128'hFFFF_8000_FFFF_7FFF_7FFF_FFFF_8000_0000;
  localparam logic [127:0] SMALL = 128'h0011_0022_0033_0044_0055_0066_0077_007F;

  initial begin
    logic [10:0] codes [9] = '{11'h00E, 11'h04E, 11'h08E, 11'h0CE, 11'h10E,
                               11'h14E, 11'h18E, 11'h1CE, 11'h30E};
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "result", result, '0);
    chk("R12", "out_valid", 128'(out_valid), 0);
    chk("R12", "sat_sticky", 128'(sat_sticky), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(1, 11'h00E, HA, HB, 0, "R2", "R2");
    step(1, 11'h04E, WA, WB, 0, "R2", "R2");
    step(1, 11'h08E, SMALL, SMALL, 0, "R3", "R9");   // no clamp, flag stays clear
    step(1, 11'h08E, HA, HB, 0, "R3", "R9");
    step(0, 11'h08E, '0, '0, 1, "R11", "R10");
    step(1, 11'h0CE, WA, WB, 0, "R3", "R9");
    step(0, 11'h0CE, '1, '1, 1, "R11", "R10");
    step(1, 11'h18E, HA, HB, 1, "R4", "R10");        // clamp with clear: ends set
    step(1, 11'h1CE, WA, WB, 1, "R4", "R10");
    step(1, 11'h18E, SMALL, SMALL, 1, "R4", "R10");  // clear with no clamp: ends clear
    step(1, 11'h10E, HA, HB, 0, "R5", "R9");
    step(0, 11'h10E, '0, '0, 1, "R11", "R10");
    step(1, 11'h14E, WA, WB, 0, "R5", "R9");
    step(0, 11'h14E, '0, '0, 0, "R11", "R9");
    step(1, 11'h30E, 128'h01FF_F8F8_0000_0000_A5C3_1E77_8080_8080, WB, 1, "R6", "R2");
    step(1, 11'h20E, HA, HB, 0, "R8", "R8");
    step(1, 11'h08E, HA, HB, 0, "R8", "R8", 6'd5);
    step(1, 11'h00E, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
         128'h1112_1314_1516_1718_191A_1B1C_1D1E_1F20, 0, "R7", "R2");
    for (int i = 0; i < 60; i++) begin
      logic [127:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      step(($urandom % 4) != 0, codes[$urandom % 9], ra, rb, ($urandom % 5) == 0, "R7", "R9");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule